// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block turns a raw power-good level and a software watchdog into three staged, active-low resets. The power-good input is first brought into the clock domain through a two-flop synchroniser and then glitch-filtered: a new level is only believed once it has been seen without interruption for a fixed number of clocks. The filtered level directly drives the reset of the boot memory, so that device wakes first and is ready to serve code fetches.

Once the boot memory is out of reset, the main controller reset is held for a further fixed stretch and then released. The reset to the peripherals is derived from the controller reset and stays asserted for a short extra interval, so release order is always boot memory, then controller, then peripherals. A low filtered input pulls all three resets at once. While the system runs, a watchdog counts clocks between kick pulses; if it reaches its limit, the controller and peripheral resets are reasserted and the stretch is replayed, while the boot memory stays out of reset and the input filter is not re-run.

A separate asynchronous cold-start input (`arst_n`) forces every register to its reset state, independent of the clock.

Top module: `por_sequencer`

## Requirements
- R1: While `arst_n` is low, `boot_rst_n`, `core_rst_n` and `periph_rst_n` are all 0.
- R2: A change of `pwr_good_raw` reaches `boot_rst_n` only if the new level persists for 65 consecutive clocks after two synchroniser stages; `boot_rst_n` changes on the 67th rising edge after the input changes, and a low pulse of 64 clocks leaves all outputs unchanged.
- R3: `core_rst_n` is never 1 while `boot_rst_n` is 0, and it only rises after `boot_rst_n` was already 1 on the previous clock.
- R4: `core_rst_n` rises exactly 256 clocks after `boot_rst_n` rises.
- R5: `periph_rst_n` rises exactly 16 clocks after `core_rst_n` rises and is never 1 while `core_rst_n` is 0.
- R6: When a low `pwr_good_raw` is accepted by the filter, all three resets become 0 on the same clock edge.
- R7: A one-clock high pulse on `wd_kick` clears the watchdog count; kicks spaced closer than the timeout (1000 clocks by default) keep all resets deasserted.
- R8: When the peripherals are out of reset and 1000 clocks (the timeout) pass from the last kick edge with no kick, `core_rst_n` and `periph_rst_n` fall together on the next edge while `boot_rst_n` stays 1; `core_rst_n` then rises 256 clocks later and `periph_rst_n` 16 clocks after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| arst_n | input | 1 | Asynchronous cold-start reset, active low |
| pwr_good_raw | input | 1 | Unsynchronised power-good level; 0 means power failure |
| wd_kick | input | 1 | Watchdog service pulse, active high, one clock |
| boot_rst_n | output | 1 | Boot memory reset, active low |
| core_rst_n | output | 1 | Main controller reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |

## Verification
Every result is counted in rising edges from the clock on which the stimulus was applied: the boot memory reset follows the input on edge 67, the controller release is due 256 edges after that and the peripheral release 16 more, and a watchdog bite shows on the edge after the 1000th unkicked one. The bench changes inputs shortly after a rising edge, advances one edge at a time with a running count, and samples the outputs just before and exactly on the edge where each change is due, so an off-by-one in any counter shows up as a mismatch. Glitches one clock shorter than the filter window are checked to have no effect on any output.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    // Stage of the release sequence after the boot memory is live
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_STRETCH = 2'd1,
        ST_PERIPH  = 2'd2,
        ST_RUN     = 2'd3
    } seq_state_e;

endpackage

// File: rtl/por_sync.sv
module por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_reg_t;

    sync_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (STAGES > 1) begin
            r_d.chain = {r_q.chain[STAGES-2:0], din};
        end else begin
            r_d.chain[0] = din;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign dout = r_q.chain[STAGES-1];

endmodule

// File: rtl/por_glitch_filter.sv
module por_glitch_filter #(
    parameter int FILT_CYC = 65
) (
    input  logic clk,
    input  logic arst_n,
    input  logic din,
    output logic level
);

    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic          level;
        logic [CW-1:0] run;
    } filt_reg_t;

    filt_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (din == r_q.level) begin
            r_d.run = '0;
        end else if (r_q.run == LAST) begin
            r_d.level = din;
            r_d.run   = '0;
        end else begin
            r_d.run = r_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '0;
        else         r_q <= r_d;
    end

    assign level = r_q.level;

endmodule

// File: rtl/por_wdog.sv
module por_wdog #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en,
    input  logic kick,
    output logic expire
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } wd_reg_t;

    wd_reg_t r_d, r_q;

    always_comb begin
        expire = en && !kick && (r_q.cnt == LAST);
        r_d    = r_q;
        if (!en || kick || expire) r_d.cnt = '0;
        else                       r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= '0;
        else         r_q <= r_d;
    end

endmodule

// File: rtl/por_stage_seq.sv
module por_stage_seq
    import por_seq_pkg::*;
#(
    parameter int STRETCH_CYC = 256,
    parameter int PERIPH_CYC  = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic boot_ok,
    input  logic bite,
    output logic core_ok,
    output logic periph_ok
);

    localparam int MAXC = (STRETCH_CYC > PERIPH_CYC) ? STRETCH_CYC : PERIPH_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] STRETCH_LAST = CW'(STRETCH_CYC - 1);
    localparam logic [CW-1:0] PERIPH_LAST  = CW'(PERIPH_CYC - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          core;
        logic          periph;
    } seq_reg_t;

    localparam seq_reg_t RST = '{state: ST_HOLD, cnt: '0, core: 1'b0, periph: 1'b0};

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!boot_ok) begin
            r_d = RST;
        end else begin
            unique case (r_q.state)
                ST_HOLD: begin
                    // first clock with the boot memory live counts as one
                    r_d.state = ST_STRETCH;
                    r_d.cnt   = CW'(1);
                end
                ST_STRETCH: begin
                    if (r_q.cnt == STRETCH_LAST) begin
                        r_d.state = ST_PERIPH;
                        r_d.cnt   = '0;
                        r_d.core  = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_PERIPH: begin
                    if (r_q.cnt == PERIPH_LAST) begin
                        r_d.state  = ST_RUN;
                        r_d.cnt    = '0;
                        r_d.periph = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (bite) begin
                        // replay the stretch; the filter is not involved
                        r_d.state  = ST_STRETCH;
                        r_d.cnt    = '0;
                        r_d.core   = 1'b0;
                        r_d.periph = 1'b0;
                    end
                end
                default: r_d = RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) r_q <= RST;
        else         r_q <= r_d;
    end

    assign core_ok   = r_q.core;
    assign periph_ok = r_q.periph;

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 65,
    parameter int STRETCH_CYC = 256,
    parameter int PERIPH_CYC  = 16,
    parameter int WD_TIMEOUT  = 1000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pwr_good_raw,
    input  logic wd_kick,
    output logic boot_rst_n,
    output logic core_rst_n,
    output logic periph_rst_n
);

    logic pg_sync;
    logic pg_filt;
    logic wd_expire;
    logic core_ok;
    logic periph_ok;

    por_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (pwr_good_raw),
        .dout   (pg_sync)
    );

    por_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk    (clk),
        .arst_n (arst_n),
        .din    (pg_sync),
        .level  (pg_filt)
    );

    por_wdog #(.TIMEOUT(WD_TIMEOUT)) u_wdog (
        .clk    (clk),
        .arst_n (arst_n),
        .en     (periph_ok),
        .kick   (wd_kick),
        .expire (wd_expire)
    );

    por_stage_seq #(
        .STRETCH_CYC (STRETCH_CYC),
        .PERIPH_CYC  (PERIPH_CYC)
    ) u_seq (
        .clk       (clk),
        .arst_n    (arst_n),
        .boot_ok   (pg_filt),
        .bite      (wd_expire),
        .core_ok   (core_ok),
        .periph_ok (periph_ok)
    );

    // each later stage is gated by the earlier one, so a power failure
    // drops all three on the same edge
    assign boot_rst_n   = pg_filt;
    assign core_rst_n   = core_ok & boot_rst_n;
    assign periph_rst_n = periph_ok & core_rst_n;

endmodule

// File: rtl/por_sequencer_chk.sv
module por_sequencer_chk (
    input logic clk,
    input logic arst_n,
    input logic pwr_good_raw,
    input logic wd_kick,
    input logic boot_rst_n,
    input logic core_rst_n,
    input logic periph_rst_n
);

    always_comb begin
        if (!arst_n) begin
            assert_cold_reset_R1: assert (!boot_rst_n && !core_rst_n && !periph_rst_n);
        end
    end

    assert_boot_fall_needs_low_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(boot_rst_n) |-> !$past(pwr_good_raw, 2));

    assert_boot_rise_needs_high_R2: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(boot_rst_n) |-> $past(pwr_good_raw, 2));

    assert_core_under_boot_R3: assert property (@(posedge clk) disable iff (!arst_n)
        core_rst_n |-> boot_rst_n);

    assert_core_rise_after_boot_R3: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(core_rst_n) |-> $past(boot_rst_n));

    assert_periph_under_core_R5: assert property (@(posedge clk) disable iff (!arst_n)
        periph_rst_n |-> core_rst_n);

    assert_periph_rise_after_core_R5: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(periph_rst_n) |-> $past(core_rst_n));

    assert_bite_without_kick_R8: assert property (@(posedge clk) disable iff (!arst_n)
        ($fell(core_rst_n) && boot_rst_n) |-> !$past(wd_kick));

endmodule

bind por_sequencer por_sequencer_chk u_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .pwr_good_raw (pwr_good_raw),
    .wd_kick      (wd_kick),
    .boot_rst_n   (boot_rst_n),
    .core_rst_n   (core_rst_n),
    .periph_rst_n (periph_rst_n)
);

// File: tb/sim_por_sequencer.sv
module sim_por_sequencer;

    localparam int FILT    = 65;
    localparam int STRETCH = 256;
    localparam int PERIPH  = 16;
    localparam int WD      = 1000;

    // {edge count after power-good rises, boot, core, periph}
    localparam int NVEC = 6;
    localparam logic [12:0] SEQ_VEC [NVEC] = '{
        {10'd66,  3'b000},   // R2: one edge before the filter accepts
        {10'd67,  3'b100},   // R2 R3: boot first
        {10'd322, 3'b100},   // R4: stretch not yet over
        {10'd323, 3'b110},   // R4: controller released
        {10'd338, 3'b110},   // R5: peripherals still held
        {10'd339, 3'b111}    // R5: peripherals released
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic arst_n;
    logic pwr_good_raw;
    logic wd_kick;
    logic boot_rst_n;
    logic core_rst_n;
    logic periph_rst_n;

    int  n_chk = 0;
    int  n_bad = 0;
    int  edges = 0;
    bit  kick_on = 1'b0;
    bit  done = 1'b0;

    por_sequencer #(
        .SYNC_STAGES (2),
        .FILT_CYC    (FILT),
        .STRETCH_CYC (STRETCH),
        .PERIPH_CYC  (PERIPH),
        .WD_TIMEOUT  (WD)
    ) u0 (
        .clk          (clk),
        .arst_n       (arst_n),
        .pwr_good_raw (pwr_good_raw),
        .wd_kick      (wd_kick),
        .boot_rst_n   (boot_rst_n),
        .core_rst_n   (core_rst_n),
        .periph_rst_n (periph_rst_n)
    );

    task automatic step();
        @(posedge clk);
        #2;
        edges++;
        wd_kick = kick_on && (edges % 50 == 0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk3(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {boot_rst_n, core_rst_n, periph_rst_n};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {boot,core,periph} got %b expected %b at edge %0d",
                     req, act, exp, edges);
        end
    endtask

    task automatic walk_table(input string tag);
        int cur;
        cur = 0;
        pwr_good_raw = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            steps(int'(SEQ_VEC[v][12:3]) - cur);
            cur = int'(SEQ_VEC[v][12:3]);
            chk3($sformatf("R2 R3 R4 R5 %s vec%0d", tag, v), SEQ_VEC[v][2:0]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        arst_n       = 1'b0;
        pwr_good_raw = 1'b0;
        wd_kick      = 1'b0;
        steps(3);
        chk3("R1 cold reset", 3'b000);
        pwr_good_raw = 1'b1;
        steps(2);
        chk3("R1 reset dominates good input", 3'b000);
        pwr_good_raw = 1'b0;
        arst_n  = 1'b1;
        kick_on = 1'b1;
        steps(2);

        // power-up sequence
        walk_table("power-up");

        // R2: a 64-clock low glitch is filtered out
        pwr_good_raw = 1'b0;
        steps(64);
        chk3("R2 during 64-clock glitch", 3'b111);
        pwr_good_raw = 1'b1;
        steps(100);
        chk3("R2 after 64-clock glitch", 3'b111);

        // R6: accepted power failure drops all resets on one edge
        pwr_good_raw = 1'b0;
        steps(66);
        chk3("R6 one edge before accept", 3'b111);
        step();
        chk3("R6 power fail accepted", 3'b000);
        steps(5);
        chk3("R6 held low", 3'b000);

        // recovery replays the whole sequence
        walk_table("recovery");

        // R7: regular kicks keep the system running
        steps(3000);
        chk3("R7 kicked for 3000 clocks", 3'b111);

        // R8: watchdog timeout
        steps(7);
        kick_on = 1'b0;
        wd_kick = 1'b1;
        step();                 // edge 1: kick sampled
        steps(WD - 1);
        chk3("R8 edge of last count", 3'b111);
        step();
        chk3("R8 bite drops core and periph", 3'b100);
        steps(STRETCH - 1);
        chk3("R8 stretch replay still held", 3'b100);
        step();
        chk3("R8 core released after replay", 3'b110);
        steps(PERIPH - 1);
        chk3("R8 periph still held", 3'b110);
        step();
        chk3("R8 periph released after replay", 3'b111);
        kick_on = 1'b1;
        steps(1500);
        chk3("R7 running after bite recovery", 3'b111);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule